// File: doc/BRIEF.md
# GPIO Port Configuration Register File

This block is the software-visible register file of a 16-pin general-purpose I/O port. It holds the per-pin configuration (direction mode, output driver type, drive speed, pull selection) and the output data, and it exposes these as plain vectors to a separate pin-level resolver. That resolver drives the pads. The resolver returns the resolved pin levels, and the block samples them into an input data register that software can read.

Software reaches the block through a simple synchronous register bus. An access is a byte address, a write strobe with 32-bit write data, and a read strobe with 32-bit read data. The bus has no back-pressure. Every strobe is accepted in the cycle it is asserted. A write takes effect at that clock edge. Read data is combinational from the current contents, in the same cycle. The output data can be changed atomically in three ways: through a combined set/clear register in which set wins, through a clear-only register, or by a plain write. Any access to an offset that holds no register produces a one-cycle error pulse.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the mode, speed and pull registers hold the parameters MODE_RST, SPEED_RST and PULL_RST. Output type, output data, input data, lock, both alternate-function registers and analog control read as zero.
- R2: A write to mode (0x00), speed (0x08), pull (0x0C), alternate-function low (0x20) or alternate-function high (0x24) stores all 32 bits. The stored value can be read back from the cycle after the write.
- R3: A write to output type (0x04), output data (0x14), lock (0x1C) or analog control (0x2C) keeps bits [15:0] and stores zero in bits [31:16].
- R4: A write to the set/clear register (0x18) sets the output data bits named in bits [15:0] and clears those named in bits [31:16]. Where both bits for a pin are 1, the pin ends up set. Other pins keep their value.
- R5: A write to the clear-only register (0x28) clears the output data bits named in bits [15:0] and leaves the others unchanged. Bits [31:16] of that write are ignored.
- R6: Reads of 0x18 and 0x28 return zero.
- R7: The input data register (0x10) samples pin_lvl_i at every clock edge. A read returns the sampled value in bits [15:0], with zero above. Writes to 0x10 change nothing.
- R8: An access at any offset other than the twelve aligned offsets listed above is undefined. This includes offsets with address bits [1:0] not zero. A read of such an offset returns zero and a write stores nothing. For each such access, err_o is high for exactly the following cycle.
- R9: mode_o, speed_o and pull_o carry the full mode, speed and pull registers. otype_o and odata_o carry bits [15:0] of output type and output data. Mode uses 2 bits per pin (01 = output) and output type uses 1 bit per pin (1 = open-drain).
- R10: rd_data_o is zero whenever rd_en_i is low. A read in the same cycle as a write to the same register returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Byte address inside the 0x400 window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| err_o | output | 1 | One-cycle pulse after an undefined access |
| pin_lvl_i | input | 16 | Resolved pin levels from the pin resolver |
| mode_o | output | 32 | Mode register, 2 bits per pin |
| otype_o | output | 16 | Output type, 1 = open-drain |
| speed_o | output | 32 | Speed register |
| pull_o | output | 32 | Pull register, 01 up, 10 down |
| odata_o | output | 16 | Output data |

## Verification
The assertions assume the bus strobes and address are stable around the rising edge and never unknown while out of reset. They also assume pin_lvl_i is a clean, defined level. The input-data check waits one cycle after reset release before it relates reads to the pin levels. The stimulus changes every input only on the falling clock edge. It keeps the pins at known values throughout, and it lets a write and a read overlap only in the one scenario that checks their ordering.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_W = 32;
  localparam int HALF_W = REG_W / 2;
  localparam int NSLOT = 8;

  // byte offsets
  localparam int OFF_MODE  = 'h00;
  localparam int OFF_OTYPE = 'h04;
  localparam int OFF_SPEED = 'h08;
  localparam int OFF_PULL  = 'h0C;
  localparam int OFF_IDR   = 'h10;
  localparam int OFF_ODR   = 'h14;
  localparam int OFF_BSR   = 'h18;
  localparam int OFF_LOCK  = 'h1C;
  localparam int OFF_AFLO  = 'h20;
  localparam int OFF_AFHI  = 'h24;
  localparam int OFF_CLR   = 'h28;
  localparam int OFF_ANA   = 'h2C;
  localparam int LAST_WORD = OFF_ANA / 4;

  // plain storage slots
  typedef enum int {
    SL_MODE = 0, SL_OTYPE = 1, SL_SPEED = 2, SL_PULL = 3,
    SL_LOCK = 4, SL_AFLO = 5, SL_AFHI = 6, SL_ANA = 7
  } slot_e;

  function automatic logic [REG_W-1:0] slot_mask(int s, int npins);
    logic [REG_W-1:0] narrow;
    narrow = (REG_W'(1) << npins) - REG_W'(1);
    if (s == SL_OTYPE || s == SL_LOCK || s == SL_ANA) return narrow;
    return '1;
  endfunction

  function automatic logic [REG_W-1:0] slot_rst(int s, logic [REG_W-1:0] mode_r,
                                                logic [REG_W-1:0] speed_r,
                                                logic [REG_W-1:0] pull_r);
    if (s == SL_MODE)  return mode_r;
    if (s == SL_SPEED) return speed_r;
    if (s == SL_PULL)  return pull_r;
    return '0;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0]    addr_i,
  output logic [NSLOT-1:0] slot_sel_o,
  output logic             idr_sel_o,
  output logic             odr_sel_o,
  output logic             bsr_sel_o,
  output logic             clr_sel_o,
  output logic             hit_o
);
  logic aligned;
  logic [AW-3:0] word;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[AW-1:2];

  always_comb begin
    slot_sel_o = '0;
    idr_sel_o  = 1'b0;
    odr_sel_o  = 1'b0;
    bsr_sel_o  = 1'b0;
    clr_sel_o  = 1'b0;
    if (aligned) begin
      case (int'(word))
        OFF_MODE/4:  slot_sel_o[SL_MODE]  = 1'b1;
        OFF_OTYPE/4: slot_sel_o[SL_OTYPE] = 1'b1;
        OFF_SPEED/4: slot_sel_o[SL_SPEED] = 1'b1;
        OFF_PULL/4:  slot_sel_o[SL_PULL]  = 1'b1;
        OFF_IDR/4:   idr_sel_o = 1'b1;
        OFF_ODR/4:   odr_sel_o = 1'b1;
        OFF_BSR/4:   bsr_sel_o = 1'b1;
        OFF_LOCK/4:  slot_sel_o[SL_LOCK]  = 1'b1;
        OFF_AFLO/4:  slot_sel_o[SL_AFLO]  = 1'b1;
        OFF_AFHI/4:  slot_sel_o[SL_AFHI]  = 1'b1;
        OFF_CLR/4:   clr_sel_o = 1'b1;
        OFF_ANA/4:   slot_sel_o[SL_ANA]   = 1'b1;
        default: ;
      endcase
    end
    hit_o = (|slot_sel_o) | idr_sel_o | odr_sel_o | bsr_sel_o | clr_sel_o;
  end
endmodule

// File: rtl/gpio_cfg_slot.sv
module gpio_cfg_slot
  import gpio_port_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = '0,
  parameter logic [REG_W-1:0] MASK    = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] d_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL & MASK;
    else if (we_i) q_o <= d_i & MASK;
  end
endmodule

// File: rtl/gpio_odata_ctrl.sv
module gpio_odata_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] d_i,
  input  logic             load_i,
  input  logic             setclr_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] q_o
);
  logic [NPINS-1:0] lo_bits, hi_bits, nxt;

  assign lo_bits = d_i[NPINS-1:0];
  assign hi_bits = d_i[HALF_W +: NPINS];

  always_comb begin
    nxt = q_o;
    if (load_i)        nxt = lo_bits;
    else if (setclr_i) nxt = (q_o & ~hi_bits) | lo_bits; // set applied last: set wins
    else if (clr_i)    nxt = q_o & ~lo_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW = 10,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] SPEED_RST = 32'h0,
  parameter logic [31:0] PULL_RST  = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             rd_en_i,
  output logic [31:0]      rd_data_o,
  output logic             err_o,
  input  logic [NPINS-1:0] pin_lvl_i,
  output logic [31:0]      mode_o,
  output logic [NPINS-1:0] otype_o,
  output logic [31:0]      speed_o,
  output logic [31:0]      pull_o,
  output logic [NPINS-1:0] odata_o
);
  logic [NSLOT-1:0] slot_sel;
  logic idr_sel, odr_sel, bsr_sel, clr_sel, hit;
  logic [REG_W-1:0] slot_q [NSLOT];
  logic [NPINS-1:0] idr_q;
  logic [NPINS-1:0] odr_q;

  gpio_addr_decode #(.AW(AW)) dec_i (
    .addr_i(addr_i), .slot_sel_o(slot_sel), .idr_sel_o(idr_sel),
    .odr_sel_o(odr_sel), .bsr_sel_o(bsr_sel), .clr_sel_o(clr_sel), .hit_o(hit)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    gpio_cfg_slot #(
      .RST_VAL(slot_rst(g, MODE_RST, SPEED_RST, PULL_RST)),
      .MASK(slot_mask(g, NPINS))
    ) slot_i (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en_i & slot_sel[g]),
      .d_i(wr_data_i), .q_o(slot_q[g])
    );
  end

  gpio_odata_ctrl #(.NPINS(NPINS)) odr_i (
    .clk(clk), .rst_n(rst_n), .d_i(wr_data_i),
    .load_i(wr_en_i & odr_sel), .setclr_i(wr_en_i & bsr_sel),
    .clr_i(wr_en_i & clr_sel), .q_o(odr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q <= '0;
      err_o <= 1'b0;
    end else begin
      idr_q <= pin_lvl_i;
      err_o <= (wr_en_i | rd_en_i) & ~hit;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      for (int s = 0; s < NSLOT; s++)
        if (slot_sel[s]) rd_data_o = slot_q[s];
      if (idr_sel) rd_data_o = REG_W'(idr_q);
      if (odr_sel) rd_data_o = REG_W'(odr_q);
    end
  end

  assign mode_o  = slot_q[SL_MODE];
  assign speed_o = slot_q[SL_SPEED];
  assign pull_o  = slot_q[SL_PULL];
  assign otype_o = slot_q[SL_OTYPE][NPINS-1:0];
  assign odata_o = odr_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic             rd_en_i,
  input logic [31:0]      rd_data_o,
  input logic             err_o,
  input logic [NPINS-1:0] pin_lvl_i,
  input logic [31:0]      mode_o,
  input logic [NPINS-1:0] odata_o
);
  logic warm_q;
  logic bad_addr;
  logic [NPINS-1:0] set_b, clr_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;

  assign bad_addr = (addr_i[1:0] != 2'b00) || (int'(addr_i[AW-1:2]) > LAST_WORD);
  assign set_b = wr_data_i[NPINS-1:0];
  assign clr_b = wr_data_i[HALF_W +: NPINS];

  a_r2_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(OFF_MODE)) |=> mode_o == $past(wr_data_i));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (addr_i == AW'(OFF_OTYPE) || addr_i == AW'(OFF_ODR) ||
                 addr_i == AW'(OFF_LOCK) || addr_i == AW'(OFF_ANA)))
    |-> rd_data_o[31:16] == 16'h0);

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(OFF_BSR)) |=>
      ((odata_o & $past(set_b)) == $past(set_b)) &&
      ((odata_o & $past(clr_b & ~set_b)) == '0));

  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(OFF_CLR)) |=> (odata_o & $past(set_b)) == '0);

  a_r6_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (addr_i == AW'(OFF_BSR) || addr_i == AW'(OFF_CLR))) |-> rd_data_o == 32'h0);

  a_r7_idr_track: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && rd_en_i && addr_i == AW'(OFF_IDR)) |-> rd_data_o == 32'($past(pin_lvl_i)));

  a_r8_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en_i || rd_en_i) && bad_addr) |=> err_o);

  a_r8_err_only: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en_i || rd_en_i) && bad_addr) |=> !err_o);

  a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && bad_addr) |-> rd_data_o == 32'h0);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> rd_data_o == 32'h0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .err_o(err_o), .pin_lvl_i(pin_lvl_i), .mode_o(mode_o), .odata_o(odata_o)
);

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;
  localparam logic [31:0] M_RST = 32'hABFF_FFFF;
  localparam logic [31:0] S_RST = 32'h0C00_0000;
  localparam logic [31:0] P_RST = 32'h6400_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic err;
  logic [15:0] pins = '0;
  logic [31:0] mode_o, speed_o, pull_o;
  logic [15:0] otype_o, odata_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_regs #(.MODE_RST(M_RST), .SPEED_RST(S_RST), .PULL_RST(P_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .err_o(err), .pin_lvl_i(pins),
    .mode_o(mode_o), .otype_o(otype_o), .speed_o(speed_o), .pull_o(pull_o),
    .odata_o(odata_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h00, v); chk("R1 mode", v, M_RST);
    rd(10'h08, v); chk("R1 speed", v, S_RST);
    rd(10'h0C, v); chk("R1 pull", v, P_RST);
    rd(10'h04, v); chk("R1 otype", v, 0);
    rd(10'h14, v); chk("R1 odata", v, 0);
    rd(10'h1C, v); chk("R1 lock", v, 0);
    rd(10'h24, v); chk("R1 afhi", v, 0);
    chk("R9 mode_o", mode_o, M_RST);
    chk("R9 pull_o", pull_o, P_RST);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr(10'h00, 32'h5555_1234); rd(10'h00, v); chk("R2 mode", v, 32'h5555_1234);
    chk("R9 mode_o", mode_o, 32'h5555_1234);
    wr(10'h20, 32'hDEAD_BEEF); rd(10'h20, v); chk("R2 aflo", v, 32'hDEAD_BEEF);
    wr(10'h08, 32'hF00F_0FF0); chk("R9 speed_o", speed_o, 32'hF00F_0FF0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(10'h04, 32'hFFFF_A5A5); rd(10'h04, v); chk("R3 otype", v, 32'h0000_A5A5);
    chk("R9 otype_o", {16'h0, otype_o}, 32'h0000_A5A5);
    wr(10'h2C, 32'h1234_5678); rd(10'h2C, v); chk("R3 analog", v, 32'h0000_5678);
    wr(10'h1C, 32'hFFFF_FFFF); rd(10'h1C, v); chk("R3 lock", v, 32'h0000_FFFF);
    wr(10'h14, 32'hABCD_00F0); rd(10'h14, v); chk("R3 odata", v, 32'h0000_00F0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(10'h14, 32'h0000_80F0);
    wr(10'h18, 32'h00F3_0003);   // clear 0,1,4..7; set 0,1
    chk("R4 set wins", {16'h0, odata_o}, 32'h0000_8003);
    rd(10'h18, v); chk("R6 setclr reads 0", v, 0);
  endtask

  task automatic t_clr();
    logic [31:0] v;
    wr(10'h14, 32'h0000_FFFF);
    wr(10'h28, 32'hFFFF_00FF);
    chk("R5 clear-only", {16'h0, odata_o}, 32'h0000_FF00);
    rd(10'h28, v); chk("R6 clear reads 0", v, 0);
  endtask

  task automatic t_idr();
    logic [31:0] v;
    @(negedge clk); pins = 16'h1234;
    @(negedge clk);
    rd(10'h10, v); chk("R7 idr sample", v, 32'h0000_1234);
    wr(10'h10, 32'hFFFF_FFFF);
    rd(10'h10, v); chk("R7 idr write ignored", v, 32'h0000_1234);
    @(negedge clk); pins = 16'hC001;
    @(negedge clk);
    rd(10'h10, v); chk("R7 idr follows", v, 32'h0000_C001);
  endtask

  task automatic t_bad();
    logic [31:0] v;
    @(negedge clk); addr = 10'h030; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 err pulse", {31'h0, err}, 1);
    @(negedge clk); chk("R8 err one cycle", {31'h0, err}, 0);
    wr(10'h002, 32'h0000_0000);     // misaligned, must not hit mode
    rd(10'h00, v); chk("R8 misaligned write ignored", v, 32'h5555_1234);
    @(negedge clk); addr = 10'h3FC; rd_en = 1'b1;
    #1 chk("R8 bad read zero", rdata, 0);
    @(negedge clk); rd_en = 1'b0;
    chk("R8 err on bad read", {31'h0, err}, 1);
  endtask

  task automatic t_rd_order();
    @(negedge clk); addr = 10'h00; rd_en = 1'b0;
    #1 chk("R10 idle zero", rdata, 0);
    @(negedge clk); addr = 10'h0C; wdata = 32'h0000_0055; wr_en = 1'b1; rd_en = 1'b1;
    #1 chk("R10 read before write", rdata, P_RST);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R10 read after write", rdata, 32'h0000_0055);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_mask();
    t_setclr();
    t_clr();
    t_idr();
    t_bad();
    t_rd_order();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule